// File: doc/BRIEF.md
# Longest Prefix Match Route Lookup

This block resolves a 32-bit IPv4 destination address to an output port. It keeps a small table of routes, each route being a prefix value, a prefix length between 1 and 32 and a port number. Every route whose leading bits agree with the address is a candidate. The candidate with the greatest prefix length gives the result, so the most specific route wins over broader ones no matter where it sits in the table. If no route applies, the block raises a miss flag.

Routes are loaded one at a time through a write port that addresses a table slot by index. A slot can be marked empty, and a slot written with an illegal length stays empty. Lookups are fully pipelined. A new address can be accepted on every clock, and each result comes back two clocks later together with the length of the winning route.

Top module: `lpm_engine`

## Requirements
- R1: A valid route matches an address when the top L bits of the address equal the top L bits of the stored prefix, where L is the route's length. The lower 32-L stored prefix bits are ignored.
- R2: Among matching routes, the one with the greatest length supplies `res_port`, whatever its slot index.
- R3: Among matching routes that share the greatest length, the route in the lowest slot index wins.
- R4: When no valid route matches, the result has `res_miss`=1, `res_port`=0 and `res_len`=0.
- R5: A write with `wr_valid`=0, or with `wr_len` equal to 0 or above 32, leaves the slot empty, and an empty slot never matches.
- R6: A lookup presented with `lk_valid`=1 at a rising edge yields `res_valid`=1 with its result after the second following rising edge. Results keep issue order, and one lookup can be accepted per clock.
- R7: A table write sampled at the same edge as a lookup does not affect that lookup. It does apply to a lookup sampled at the next edge.
- R8: Reset (`rst_n`=0) empties every slot and clears `res_valid`.
- R9: While `res_valid`=0, `res_port`, `res_miss` and `res_len` are all 0.
- R10: On a hit, `res_len` equals the length (1 to 32) of the winning route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table slot this cycle |
| wr_idx | input | IDX_W | Slot index to write |
| wr_valid | input | 1 | 1 stores a live route, 0 empties the slot |
| wr_prefix | input | 32 | Route prefix value |
| wr_len | input | 6 | Route prefix length, legal range 1 to 32 |
| wr_port | input | PORT_W | Route output port |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Destination address to resolve |
| res_valid | output | 1 | Result available |
| res_miss | output | 1 | No route matched |
| res_port | output | PORT_W | Port of the winning route |
| res_len | output | 6 | Length of the winning route |

## Verification
The bench builds the block with four slots and 3-bit ports. With that size, every slot can be loaded, overwritten and emptied inside a short run, and the full set of ties and overlaps is easy to set up. A single route is swept through all 32 lengths. At each length it is probed with the exact prefix, with the last covered bit flipped and with the first uncovered bit flipped, which reaches every mask boundary. A bench model of the table then checks a long stream of back-to-back lookups mixed with writes, including writes in the same cycle as a lookup.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 6;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;

    // Ones in the top 'len' bit positions.
    function automatic addr_t len_mask(input len_t len);
        if (len == '0) return '0;
        return ~({ADDR_W{1'b1}} >> len);
    endfunction

    function automatic logic len_legal(input len_t len);
        return (len != '0) && (int'(len) <= ADDR_W);
    endfunction
endpackage

// File: rtl/lpm_table.sv
module lpm_table
    import lpm_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int PORT_W    = 4,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic                              wr_valid,
    input  addr_t                             wr_prefix,
    input  len_t                              wr_len,
    input  logic [PORT_W-1:0]                 wr_port,
    output logic [N_ENTRIES-1:0]              ent_vld,
    output addr_t [N_ENTRIES-1:0]             ent_pre,
    output len_t  [N_ENTRIES-1:0]             ent_len,
    output logic [N_ENTRIES-1:0][PORT_W-1:0]  ent_port
);
    typedef struct packed {
        logic              vld;
        addr_t             pre;
        len_t              len;
        logic [PORT_W-1:0] port;
    } entry_t;

    entry_t [N_ENTRIES-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (IDX_W'(i) == wr_idx) begin
                    tab_d[i].vld  = wr_valid && len_legal(wr_len);
                    tab_d[i].pre  = wr_prefix;
                    tab_d[i].len  = wr_len;
                    tab_d[i].port = wr_port;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_out
        assign ent_vld[g]  = tab_q[g].vld;
        assign ent_pre[g]  = tab_q[g].pre;
        assign ent_len[g]  = tab_q[g].len;
        assign ent_port[g] = tab_q[g].port;
    end
endmodule

// File: rtl/lpm_match_stage.sv
module lpm_match_stage
    import lpm_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int PORT_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lk_valid,
    input  addr_t                             lk_addr,
    input  logic [N_ENTRIES-1:0]              ent_vld,
    input  addr_t [N_ENTRIES-1:0]             ent_pre,
    input  len_t  [N_ENTRIES-1:0]             ent_len,
    input  logic [N_ENTRIES-1:0][PORT_W-1:0]  ent_port,
    output logic                              m_vld,
    output len_t  [N_ENTRIES-1:0]             m_len,
    output logic [N_ENTRIES-1:0][PORT_W-1:0]  m_port
);
    typedef struct packed {
        logic                             vld;
        len_t [N_ENTRIES-1:0]             len;
        logic [N_ENTRIES-1:0][PORT_W-1:0] port;
    } stage_t;

    stage_t st_d, st_q;
    logic [N_ENTRIES-1:0] hit;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit[g] = ent_vld[g] &&
                        (((lk_addr ^ ent_pre[g]) & len_mask(ent_len[g])) == '0);
    end

    // Snapshot length and port of every hit so later writes cannot leak in.
    always_comb begin
        st_d.vld = lk_valid;
        for (int i = 0; i < N_ENTRIES; i++) begin
            st_d.len[i]  = (lk_valid && hit[i]) ? ent_len[i]  : '0;
            st_d.port[i] = (lk_valid && hit[i]) ? ent_port[i] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_vld  = st_q.vld;
    assign m_len  = st_q.len;
    assign m_port = st_q.port;
endmodule

// File: rtl/lpm_pick_stage.sv
module lpm_pick_stage
    import lpm_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int PORT_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              m_vld,
    input  len_t  [N_ENTRIES-1:0]             m_len,
    input  logic [N_ENTRIES-1:0][PORT_W-1:0]  m_port,
    output logic                              res_valid,
    output logic                              res_miss,
    output logic [PORT_W-1:0]                 res_port,
    output len_t                              res_len
);
    typedef struct packed {
        logic              vld;
        logic              miss;
        logic [PORT_W-1:0] port;
        len_t              len;
    } result_t;

    result_t st_d, st_q;

    // Strictly-greater scan from slot 0 keeps the lowest index on ties.
    always_comb begin
        st_d      = '0;
        st_d.vld  = m_vld;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (m_len[i] > st_d.len) begin
                st_d.len  = m_len[i];
                st_d.port = m_port[i];
            end
        end
        st_d.miss = m_vld && (st_d.len == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign res_miss  = st_q.miss;
    assign res_port  = st_q.port;
    assign res_len   = st_q.len;
endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
    import lpm_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int PORT_W    = 4,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [31:0]       wr_prefix,
    input  logic [5:0]        wr_len,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              res_valid,
    output logic              res_miss,
    output logic [PORT_W-1:0] res_port,
    output logic [5:0]        res_len
);
    logic [N_ENTRIES-1:0]             ent_vld;
    addr_t [N_ENTRIES-1:0]            ent_pre;
    len_t  [N_ENTRIES-1:0]            ent_len;
    logic [N_ENTRIES-1:0][PORT_W-1:0] ent_port;
    logic                             m_vld;
    len_t  [N_ENTRIES-1:0]            m_len;
    logic [N_ENTRIES-1:0][PORT_W-1:0] m_port;

    lpm_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
        .ent_vld(ent_vld), .ent_pre(ent_pre), .ent_len(ent_len), .ent_port(ent_port)
    );

    lpm_match_stage #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .ent_vld(ent_vld), .ent_pre(ent_pre), .ent_len(ent_len), .ent_port(ent_port),
        .m_vld(m_vld), .m_len(m_len), .m_port(m_port)
    );

    lpm_pick_stage #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .m_vld(m_vld), .m_len(m_len), .m_port(m_port),
        .res_valid(res_valid), .res_miss(res_miss), .res_port(res_port), .res_len(res_len)
    );
endmodule

// File: rtl/lpm_engine_chk.sv
module lpm_engine_chk #(
    parameter int PORT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              res_valid,
    input logic              res_miss,
    input logic [PORT_W-1:0] res_port,
    input logic [5:0]        res_len
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2) age_q <= age_q + 2'd1;
    end

    a_r4_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_port == '0 && res_len == '0));

    a_r6_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2) |-> (res_valid == $past(lk_valid, 2)));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_miss && res_port == '0 && res_len == '0));

    a_r10_hit_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_miss) |-> (res_len >= 6'd1 && res_len <= 6'd32));
endmodule

bind lpm_engine lpm_engine_chk #(.PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .res_valid(res_valid), .res_miss(res_miss), .res_port(res_port), .res_len(res_len)
);

// File: tb/lpm_engine_test.sv
module lpm_engine_test;
    localparam int N  = 4;
    localparam int PW = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_valid = 1'b0;
    logic [31:0]   wr_prefix = '0;
    logic [5:0]    wr_len = '0;
    logic [PW-1:0] wr_port = '0;
    logic          lk_valid = 1'b0;
    logic [31:0]   lk_addr = '0;
    logic          res_valid, res_miss;
    logic [PW-1:0] res_port;
    logic [5:0]    res_len;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench model of the table
    bit          m_vld [N];
    logic [31:0] m_pre [N];
    int          m_len [N];
    int          m_port[N];

    // expected-result queue
    bit    q_miss[256];
    int    q_port[256];
    int    q_len [256];
    int    q_cyc [256];
    string q_tag [256];
    int    q_wr = 0;
    int    q_rd = 0;

    lpm_engine #(.N_ENTRIES(N), .PORT_W(PW)) uut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    endtask

    // Top L bits compared by shifting, L in 1..32.
    task automatic model_lookup(input logic [31:0] a, output bit miss, output int port, output int len);
        miss = 1'b1; port = 0; len = 0;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && ((a >> (32 - m_len[i])) == (m_pre[i] >> (32 - m_len[i])))
                && m_len[i] > len) begin
                len = m_len[i]; port = m_port[i]; miss = 1'b0;
            end
        end
    endtask

    // One cycle: optional lookup and optional write, both sampled at the next edge.
    task automatic drive(input bit lk, input logic [31:0] a, input string tag,
                         input bit wr, input int idx, input bit v,
                         input logic [31:0] pre, input int len, input int port);
        bit e_miss; int e_port, e_len;
        @(negedge clk);
        lk_valid = lk; lk_addr = a;
        wr_en = wr; wr_idx = IW'(idx); wr_valid = v;
        wr_prefix = pre; wr_len = 6'(len); wr_port = PW'(port);
        if (lk) begin
            model_lookup(a, e_miss, e_port, e_len);
            q_miss[q_wr % 256] = e_miss; q_port[q_wr % 256] = e_port;
            q_len[q_wr % 256] = e_len; q_cyc[q_wr % 256] = cyc; q_tag[q_wr % 256] = tag;
            q_wr++;
        end
        if (wr) begin
            m_vld[idx] = v && len >= 1 && len <= 32;
            m_pre[idx] = pre; m_len[idx] = len; m_port[idx] = port;
        end
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        drive(1'b1, a, tag, 1'b0, 0, 1'b0, 32'h0, 0, 0);
    endtask

    task automatic put(input int idx, input bit v, input logic [31:0] pre, input int len, input int port);
        drive(1'b0, 32'h0, "", 1'b1, idx, v, pre, len, port);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 32'h0, "", 1'b0, 0, 1'b0, 32'h0, 0, 0);
    endtask

    // Result checker
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                if (q_rd >= q_wr) begin
                    report(1'b0, "R6", "result with no lookup outstanding");
                end else begin
                    int s;
                    s = q_rd % 256;
                    report(cyc - q_cyc[s] == 2, "R6",
                           $sformatf("latency %0d exp 2", cyc - q_cyc[s]));
                    report(res_miss == q_miss[s] && int'(res_port) == q_port[s] && int'(res_len) == q_len[s],
                           q_tag[s],
                           $sformatf("miss/port/len act %0d/%0d/%0d exp %0d/%0d/%0d",
                                     res_miss, res_port, res_len, q_miss[s], q_port[s], q_len[s]));
                    q_rd++;
                end
            end else if (q_rd < q_wr && cyc - q_cyc[q_rd % 256] >= 2) begin
                report(1'b0, "R6", "result missing after two edges");
                q_rd++;
            end else begin
                report(!res_miss && res_port == '0 && res_len == '0, "R9",
                       $sformatf("idle outputs miss/port/len act %0d/%0d/%0d exp 0/0/0",
                                 res_miss, res_port, res_len));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, act hung exp done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        report(res_valid == 1'b0 && res_port == '0 && res_miss == 1'b0, "R8",
               $sformatf("reset outputs valid/port act %0d/%0d exp 0/0", res_valid, res_port));
        rst_n = 1'b1;

        // R4: empty table misses
        look(32'h0A000001, "R4");
        look(32'hFFFFFFFF, "R4");

        // R2 R10: worked route example; slot 3 holds the /21
        put(0, 1, {8'd65, 24'd0}, 8, 3);
        put(1, 1, {8'd128, 8'd9, 16'd0}, 16, 1);
        put(2, 1, {8'd142, 8'd12, 16'd0}, 19, 7);
        put(3, 1, {8'd128, 8'd9, 8'd16, 8'd0}, 21, 5);
        look({8'd128, 8'd9, 8'd16, 8'd14}, "R2");
        look({8'd128, 8'd9, 8'd200, 8'd1}, "R2");
        look({8'd65, 8'd1, 8'd2, 8'd3}, "R10");
        look({8'd142, 8'd12, 8'd31, 8'd255}, "R10");
        look({8'd142, 8'd12, 8'd32, 8'd0}, "R4");
        look({8'd10, 8'd0, 8'd0, 8'd0}, "R4");

        // R3: equal lengths tie to the lower slot
        put(1, 1, 32'hC0A80000, 16, 2);
        put(2, 1, 32'hC0A8FFFF, 16, 6);
        look(32'hC0A81234, "R3");
        put(1, 0, 32'h0, 16, 0);
        look(32'hC0A81234, "R3");

        // R5: invalid writes leave the slot empty
        model_clear();
        for (int i = 0; i < N; i++) put(i, 0, 32'h0, 8, 0);
        put(0, 1, 32'h0, 0, 4);
        put(1, 1, 32'h12345678, 40, 4);
        put(2, 1, 32'h12345678, 33, 4);
        look(32'h12345678, "R5");
        look(32'h00000000, "R5");

        // R1 R10: sweep one route through every length
        model_clear();
        for (int i = 0; i < N; i++) put(i, 0, 32'h0, 8, 0);
        for (int len = 1; len <= 32; len++) begin
            put(0, 1, 32'hA5A5A5A5, len, len % 8);
            look(32'hA5A5A5A5, "R1");
            look(32'hA5A5A5A5 ^ (32'h1 << (32 - len)), "R1");
            if (len < 32) look(32'hA5A5A5A5 ^ (32'h1 << (31 - len)), "R1");
        end
        // lower stored bits ignored
        put(0, 1, 32'h0AFFFFFF, 8, 2);
        look(32'h0A000000, "R1");

        // R7: write and lookup in the same cycle
        put(1, 1, 32'h0A0B0000, 16, 6);
        drive(1'b1, 32'h0A0B0C0D, "R7", 1'b1, 2, 1'b1, 32'h0A0B0C00, 24, 7);
        look(32'h0A0B0C0D, "R7");
        drive(1'b1, 32'h0A0B0C0D, "R7", 1'b1, 2, 1'b0, 32'h0, 24, 0);
        look(32'h0A0B0C0D, "R7");

        // R6: back-to-back stream with interleaved writes
        lfsr = 32'hACE1BEEF;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = (k % 2 == 0) ? {8'h0A, lfsr[23:0]} : lfsr;
            if (k % 7 == 3)
                drive(1'b1, a, "R6", 1'b1, k % N, 1'b1, {8'h0A, lfsr[31:8]},
                      1 + (int'(lfsr[4:0]) % 32), int'(lfsr[7:5]));
            else
                look(a, "R6");
        end
        idle(4);
        report(q_rd == q_wr, "R6", $sformatf("results act %0d exp %0d", q_rd, q_wr));

        // R8: reset empties the table
        model_clear();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(32'h0A000000, "R8");
        look(32'hA5A5A5A5, "R8");
        idle(4);
        report(q_rd == q_wr, "R6", $sformatf("results act %0d exp %0d", q_rd, q_wr));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule